// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous user port and an external 16-bit asynchronous static RAM with an 18-bit word address. It takes one read or write request at a time, with a per-byte mask, over a valid/ready handshake. It then sequences the active-low chip-select, write-strobe, read-strobe and two byte-lane strobes of the memory. Each phase lasts a fixed number of clock cycles. The count for each phase is computed at elaboration from the memory's timing limits, given in picoseconds, and the clock period. The result is rounded up to whole cycles.

A write holds the address and byte strobes steady while the write strobe is low. The write strobe is released first, so it is the signal that ends the write. The data stays on the bus for one more cycle after that. A read keeps the write strobe high and only the requested lanes enabled. It captures the returned word on the last cycle of the access time. Lanes outside the mask read back as zero. After every read the controller waits out the memory's output release time before it accepts anything new. The data bus is split into an output word, a per-lane drive enable and an input word, so the pad ring builds the tristate.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset, and whenever idle, `req_ready` is 1. All five memory strobes are 1 (inactive), `sram_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A write drives `sram_we_n` low for exactly WR_PULSE cycles. WR_PULSE is the largest of write-strobe width, lane-strobe width, address-to-end and data-setup, each rounded up to cycles; the default is 10 at 4 ns. During this time `sram_ce_n` is low and `sram_oe_n` is high. `req_be[0]` selects lane 0 (bits 7:0, strobe `sram_lb_n`) and `req_be[1]` selects lane 1 (bits 15:8, strobe `sram_ub_n`). Each selected lane has its strobe low and its `sram_dq_oe` bit set, with the request data on `sram_dq_o`.
- R3: While `sram_we_n` is low, and in the cycle in which it returns high, `sram_addr`, `sram_dq_o` and `sram_dq_oe` do not change and `sram_ce_n` stays low.
- R4: A write keeps `sram_ce_n` low for the full write cycle time in cycles (default 14). `req_ready` returns 14 cycles after the accepting edge.
- R5: A read holds `sram_ce_n` and `sram_oe_n` low and `sram_we_n` high, with `sram_dq_oe` at 0, for the read access time in cycles (default 14). The word is captured on the last of those cycles. Lanes not selected in the mask return 0 in `rsp_rdata`.
- R6: `rsp_valid` is a single-cycle pulse. It is first seen 14 cycles after the accepting edge for both reads and writes.
- R7: After a read, all strobes are high, nothing is driven and `req_ready` is low for the release time in cycles (default 5). `req_ready` returns 19 cycles after the accepting edge.
- R8: `req_ready` is high only in idle. A request held valid during a busy access is accepted at the first idle edge and not before.
- R9: `sram_we_n` and `sram_oe_n` are never low together. No lane is driven while `sram_oe_n` is low.
- R10: A write with an all-zero mask keeps both lane strobes high, drives nothing and leaves memory unchanged. It still completes with the normal timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit i selects lane i |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| sram_addr | output | 18 | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Read strobe, active low |
| sram_ub_n | output | 1 | Lane 1 strobe, active low |
| sram_lb_n | output | 1 | Lane 0 strobe, active low |
| sram_dq_o | output | 16 | Data toward memory |
| sram_dq_oe | output | 2 | Per-lane drive enable |
| sram_dq_i | input | 16 | Data from memory |

## Verification
The bound checker watches every cycle for these properties:
- The idle strobes are all inactive.
- The write strobe never overlaps the read strobe and never appears outside chip select.
- The write pulse reaches its minimum width.
- Address and data stay frozen through the pulse and its release cycle.
- No lane is driven inside the release window after a read.
- The completion pulse lasts one cycle.

The bench scenarios are needed for the rest:
- That the right lanes land in memory, and that masked lanes read as zero.
- That the word is captured only once the access time has elapsed. The bench's memory model returns junk until then.
- That an empty mask leaves memory untouched.
- That a held request waits for idle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_PULSE,
    ST_WR_TAIL,
    ST_RD_ACC,
    ST_TURN
  } ctrl_state_e;

  // time in ps -> whole clock cycles, rounded up
  function automatic int ps_to_cycles(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_interval_timer.sv
module sram_interval_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       sel_in,
  input  logic [7:0] wdata_in,
  input  logic       lane_on_d,
  input  logic       drive_d,
  input  logic       capture,
  input  logic [7:0] dq_i,
  output logic       be_n,
  output logic [7:0] dq_o,
  output logic       dq_oe,
  output logic [7:0] rdata
);

  logic sel_q;
  logic sel_d;

  assign sel_d = load ? sel_in : sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      be_n  <= 1'b1;
      dq_o  <= '0;
      dq_oe <= 1'b0;
      rdata <= '0;
    end else begin
      sel_q <= sel_d;
      be_n  <= !(lane_on_d && sel_d);
      dq_oe <= drive_d && sel_d;
      if (load) begin
        dq_o <= wdata_in;
      end
      if (capture) begin
        rdata <= sel_q ? dq_i : 8'h00;
      end
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int CLK_PS    = 4000,
  parameter int T_PWE_PS  = 40000,
  parameter int T_BW_PS   = 40000,
  parameter int T_AW_PS   = 40000,
  parameter int T_SD_PS   = 25000,
  parameter int T_WC_PS   = 55000,
  parameter int T_AA_PS   = 55000,
  parameter int T_DOE_PS  = 25000,
  parameter int T_RC_PS   = 55000,
  parameter int T_HZ_PS   = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_ub_n,
  output logic              sram_lb_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic [DATA_W/8-1:0] sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int LANES = DATA_W / 8;

  localparam int WR_PULSE_CYC = max2(
    max2(ps_to_cycles(T_PWE_PS, CLK_PS), ps_to_cycles(T_BW_PS, CLK_PS)),
    max2(ps_to_cycles(T_AW_PS, CLK_PS),  ps_to_cycles(T_SD_PS, CLK_PS)));
  localparam int WR_TAIL_CYC  = max2(ps_to_cycles(T_WC_PS, CLK_PS) - WR_PULSE_CYC, 1);
  localparam int RD_ACC_CYC   = max2(
    max2(ps_to_cycles(T_AA_PS, CLK_PS), ps_to_cycles(T_DOE_PS, CLK_PS)),
    ps_to_cycles(T_RC_PS, CLK_PS));
  localparam int TURN_CYC     = max2(ps_to_cycles(T_HZ_PS, CLK_PS), 1);
  localparam int MAX_CYC      = max2(max2(WR_PULSE_CYC, WR_TAIL_CYC),
                                     max2(RD_ACC_CYC, TURN_CYC));
  localparam int CNT_W        = $clog2(MAX_CYC + 1);

  ctrl_state_e st_q, st_d;

  // named internal events
  logic             accept;
  logic             timer_done;
  logic             timer_load;
  logic [CNT_W-1:0] timer_val;
  logic             rd_capture;
  logic             acc_done;
  logic             nxt_ce, nxt_we, nxt_oe, nxt_drive;
  logic [LANES-1:0] lane_be_n;

  assign req_ready  = (st_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign rd_capture = (st_q == ST_RD_ACC) && timer_done;
  assign acc_done   = timer_done && ((st_q == ST_RD_ACC) || (st_q == ST_WR_TAIL));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (req_valid) st_d = req_write ? ST_WR_PULSE : ST_RD_ACC;
      ST_WR_PULSE: if (timer_done) st_d = ST_WR_TAIL;
      ST_WR_TAIL:  if (timer_done) st_d = ST_IDLE;
      ST_RD_ACC:   if (timer_done) st_d = ST_TURN;
      ST_TURN:     if (timer_done) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    timer_load = (st_d != st_q) && (st_d != ST_IDLE);
    unique case (st_d)
      ST_WR_PULSE: timer_val = CNT_W'(WR_PULSE_CYC - 1);
      ST_WR_TAIL:  timer_val = CNT_W'(WR_TAIL_CYC - 1);
      ST_RD_ACC:   timer_val = CNT_W'(RD_ACC_CYC - 1);
      ST_TURN:     timer_val = CNT_W'(TURN_CYC - 1);
      default:     timer_val = '0;
    endcase
  end

  // strobe levels for the coming cycle, registered below
  assign nxt_ce    = (st_d == ST_WR_PULSE) || (st_d == ST_WR_TAIL) || (st_d == ST_RD_ACC);
  assign nxt_we    = (st_d == ST_WR_PULSE);
  assign nxt_oe    = (st_d == ST_RD_ACC);
  assign nxt_drive = (st_d == ST_WR_PULSE) || (st_d == ST_WR_TAIL);

  sram_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (timer_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      sram_ce_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_oe_n <= 1'b1;
      rsp_valid <= 1'b0;
      sram_addr <= '0;
    end else begin
      st_q      <= st_d;
      sram_ce_n <= !nxt_ce;
      sram_we_n <= !nxt_we;
      sram_oe_n <= !nxt_oe;
      rsp_valid <= acc_done;
      if (accept) begin
        sram_addr <= req_addr;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_byte_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .sel_in    (req_be[g]),
      .wdata_in  (req_wdata[g*8 +: 8]),
      .lane_on_d (nxt_ce),
      .drive_d   (nxt_drive),
      .capture   (rd_capture),
      .dq_i      (sram_dq_i[g*8 +: 8]),
      .be_n      (lane_be_n[g]),
      .dq_o      (sram_dq_o[g*8 +: 8]),
      .dq_oe     (sram_dq_oe[g]),
      .rdata     (rsp_rdata[g*8 +: 8])
    );
  end

  assign sram_lb_n = lane_be_n[0];
  assign sram_ub_n = lane_be_n[LANES-1];

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int WR_PULSE_CYC = 10,
  parameter int TURN_CYC     = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                rsp_valid,
  input logic                rd_capture,
  input logic                sram_ce_n,
  input logic                sram_we_n,
  input logic                sram_oe_n,
  input logic                sram_ub_n,
  input logic                sram_lb_n,
  input logic [ADDR_W-1:0]   sram_addr,
  input logic [DATA_W-1:0]   sram_dq_o,
  input logic [DATA_W/8-1:0] sram_dq_oe
);

  logic [15:0] we_low_cnt;
  logic [15:0] hz_cnt;
  logic        oe_n_q;
  logic        hz_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
      hz_cnt     <= 16'(TURN_CYC);
      oe_n_q     <= 1'b1;
    end else begin
      oe_n_q <= sram_oe_n;
      if (!sram_we_n) begin
        if (we_low_cnt != 16'hFFFF) we_low_cnt <= we_low_cnt + 16'd1;
      end else begin
        we_low_cnt <= '0;
      end
      if (sram_oe_n && !oe_n_q) begin
        hz_cnt <= 16'd1;
      end else if (hz_cnt < 16'(TURN_CYC)) begin
        hz_cnt <= hz_cnt + 16'd1;
      end
    end
  end

  assign hz_win = (sram_oe_n && !oe_n_q) || (hz_cnt < 16'(TURN_CYC));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && sram_ub_n && sram_lb_n && sram_dq_oe == '0));

  p_we_inside_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce_n && sram_oe_n));

  p_we_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (int'(we_low_cnt) >= WR_PULSE_CYC));

  p_wr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && !$past(sram_we_n)) |->
      ($stable(sram_dq_o) && $stable(sram_addr) && $stable(sram_dq_oe)));

  p_wr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |->
      ($stable(sram_dq_o) && $stable(sram_addr) && $stable(sram_dq_oe) && !sram_ce_n));

  p_capture_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> rsp_valid);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_release_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hz_win |-> (sram_dq_oe == '0));

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n));

  p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe != '0) |-> sram_oe_n);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W),
  .WR_PULSE_CYC (WR_PULSE_CYC),
  .TURN_CYC     (TURN_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rd_capture (rd_capture),
  .sram_ce_n  (sram_ce_n),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_ub_n  (sram_ub_n),
  .sram_lb_n  (sram_lb_n),
  .sram_addr  (sram_addr),
  .sram_dq_o  (sram_dq_o),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;

  localparam int CLK_PS = 4000;

  function automatic int cyc(input int t_ps);
    int n;
    n = t_ps / CLK_PS;
    if (n * CLK_PS < t_ps) n = n + 1;
    return n;
  endfunction

  localparam int EXP_WP = 10;  // 40 ns / 4 ns
  localparam int EXP_WC = 14;  // 55 ns / 4 ns rounded up
  localparam int EXP_RD = 14;
  localparam int EXP_TA = 5;   // 20 ns / 4 ns

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] sram_addr;
  logic        sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n;
  logic [15:0] sram_dq_o;
  logic [1:0]  sram_dq_oe;
  logic [15:0] sram_dq_i;

  always #2 clk = ~clk;

  sram_async_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  // memory model: junk until the access time has elapsed
  logic [15:0] mem [256];
  logic [15:0] shadow [256];
  int          rd_age;
  logic        rd_ok;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 16'h0000;
      rd_age <= 0;
    end else begin
      if (!sram_ce_n && !sram_we_n) begin
        if (!sram_lb_n && sram_dq_oe[0]) mem[sram_addr[7:0]][7:0]  <= sram_dq_o[7:0];
        if (!sram_ub_n && sram_dq_oe[1]) mem[sram_addr[7:0]][15:8] <= sram_dq_o[15:8];
      end
      if (!sram_ce_n && !sram_oe_n && sram_we_n) rd_age <= rd_age + 1;
      else rd_age <= 0;
    end
  end

  always_comb begin
    rd_ok = !sram_ce_n && !sram_oe_n && sram_we_n && (rd_age >= cyc(55000) - 1);
    sram_dq_i[7:0]  = (rd_ok && !sram_lb_n) ? mem[sram_addr[7:0]][7:0]  : 8'hEE;
    sram_dq_i[15:8] = (rd_ok && !sram_ub_n) ? mem[sram_addr[7:0]][15:8] : 8'hDD;
  end

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 20000 && !finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", wd_cnt);
      finish_run();
    end
  end

  // observations from one access
  int          o_we_low, o_oe_low, o_rsp_k, o_rsp_n, o_rdy_k;
  logic [15:0] o_rdata, o_dq_k0;
  logic [17:0] o_addr_k0;
  logic [1:0]  o_be_k0, o_oe_k0;
  bit          o_turn_drive, o_any_be_low, o_any_drive, o_overlap, o_unstable;

  task automatic run_access(input bit wr, input logic [17:0] a,
                            input logic [15:0] d, input logic [1:0] be);
    bit prev_we_low;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    o_we_low = 0; o_oe_low = 0; o_rsp_k = -1; o_rsp_n = 0; o_rdy_k = -1;
    o_rdata = '0; o_turn_drive = 0; o_any_be_low = 0; o_any_drive = 0;
    o_overlap = 0; o_unstable = 0; prev_we_low = 0;
    o_dq_k0 = sram_dq_o; o_addr_k0 = sram_addr;
    o_be_k0 = {sram_ub_n, sram_lb_n}; o_oe_k0 = sram_dq_oe;
    for (int k = 0; k < 24; k++) begin
      if (!sram_we_n) o_we_low++;
      if (!sram_oe_n) o_oe_low++;
      if (rsp_valid) begin
        o_rsp_n++;
        if (o_rsp_k < 0) begin o_rsp_k = k; o_rdata = rsp_rdata; end
      end
      if (req_ready && o_rdy_k < 0) o_rdy_k = k;
      if (!wr && k >= EXP_RD && k < EXP_RD + EXP_TA && sram_dq_oe != 0) o_turn_drive = 1;
      if (!sram_ub_n || !sram_lb_n) o_any_be_low = 1;
      if (sram_dq_oe != 0) o_any_drive = 1;
      if ((!sram_we_n && !sram_oe_n) || (sram_dq_oe != 0 && !sram_oe_n)) o_overlap = 1;
      if ((!sram_we_n || prev_we_low) &&
          (sram_dq_o != o_dq_k0 || sram_addr != o_addr_k0 || sram_dq_oe != o_oe_k0)) o_unstable = 1;
      prev_we_low = !sram_we_n;
      @(negedge clk);
    end
    if (wr) begin
      if (be[0]) shadow[a[7:0]][7:0]  = d[7:0];
      if (be[1]) shadow[a[7:0]][15:8] = d[15:8];
    end
  endtask

  function automatic logic [15:0] masked(input logic [15:0] v, input logic [1:0] be);
    return {be[1] ? v[15:8] : 8'h00, be[0] ? v[7:0] : 8'h00};
  endfunction

  task automatic t_reset();
    check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    check({sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n} == 5'b11111,
          "R1 strobes", int'({sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n}), 'h1f);
    check(sram_dq_oe == 2'b00 && rsp_valid == 1'b0, "R1 drive/rsp",
          int'({sram_dq_oe, rsp_valid}), 0);
  endtask

  task automatic t_full_write_read();
    run_access(1'b1, 18'h2A5C3, 16'h1234, 2'b11);
    check(o_we_low == EXP_WP, "R2 we width", o_we_low, EXP_WP);
    check(o_be_k0 == 2'b00 && o_oe_k0 == 2'b11, "R2 lanes", int'({o_be_k0, o_oe_k0}), 'h3);
    check(o_dq_k0 == 16'h1234 && o_addr_k0 == 18'h2A5C3, "R2 data/addr", int'(o_dq_k0), 'h1234);
    check(o_oe_low == 0, "R2 oe high", o_oe_low, 0);
    check(!o_unstable, "R3 stable", int'(o_unstable), 0);
    check(o_rdy_k == EXP_WC, "R4 write cycle", o_rdy_k, EXP_WC);
    check(o_rsp_k == EXP_WC && o_rsp_n == 1, "R6 write done", o_rsp_k, EXP_WC);
    check(!o_overlap, "R9 write", int'(o_overlap), 0);
    run_access(1'b0, 18'h2A5C3, 16'h0000, 2'b11);
    check(o_oe_low == EXP_RD && o_we_low == 0 && !o_any_drive, "R5 read strobes", o_oe_low, EXP_RD);
    check(o_rdata == 16'h1234, "R5 read data", int'(o_rdata), 'h1234);
    check(o_rsp_k == EXP_RD && o_rsp_n == 1, "R6 read done", o_rsp_k, EXP_RD);
    check(o_rdy_k == EXP_RD + EXP_TA && !o_turn_drive, "R7 release", o_rdy_k, EXP_RD + EXP_TA);
    check(!o_overlap, "R9 read", int'(o_overlap), 0);
  endtask

  task automatic t_byte_lanes();
    run_access(1'b1, 18'h00040, 16'hA1B2, 2'b11);
    run_access(1'b1, 18'h00040, 16'hCCFF, 2'b10);
    check(o_be_k0 == 2'b01 && o_oe_k0 == 2'b10, "R2 upper lane", int'({o_be_k0, o_oe_k0}), 'h6);
    run_access(1'b1, 18'h00040, 16'hFF77, 2'b01);
    check(o_be_k0 == 2'b10 && o_oe_k0 == 2'b01, "R2 lower lane", int'({o_be_k0, o_oe_k0}), 'h9);
    run_access(1'b0, 18'h00040, 16'h0, 2'b11);
    check(o_rdata == shadow[8'h40], "R2 merged", int'(o_rdata), int'(shadow[8'h40]));
    run_access(1'b0, 18'h00040, 16'h0, 2'b10);
    check(o_rdata == masked(shadow[8'h40], 2'b10), "R5 upper read", int'(o_rdata),
          int'(masked(shadow[8'h40], 2'b10)));
    run_access(1'b0, 18'h00040, 16'h0, 2'b01);
    check(o_rdata == masked(shadow[8'h40], 2'b01), "R5 lower read", int'(o_rdata),
          int'(masked(shadow[8'h40], 2'b01)));
  endtask

  task automatic t_empty_mask();
    run_access(1'b1, 18'h00077, 16'h5566, 2'b11);
    run_access(1'b1, 18'h00077, 16'hFFFF, 2'b00);
    check(!o_any_be_low && !o_any_drive, "R10 no lanes", int'({o_any_be_low, o_any_drive}), 0);
    check(o_rsp_k == EXP_WC && o_rdy_k == EXP_WC, "R10 timing", o_rsp_k, EXP_WC);
    run_access(1'b0, 18'h00077, 16'h0, 2'b11);
    check(o_rdata == 16'h5566, "R10 unchanged", int'(o_rdata), 'h5566);
  endtask

  task automatic t_busy_hold();
    int  we_k, rdy_k;
    bit  early_drive;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00040; req_be = 2'b11;
    @(posedge clk);
    @(negedge clk);
    req_write = 1'b1; req_addr = 18'h00099; req_wdata = 16'h4C3D; req_be = 2'b11;
    we_k = -1; rdy_k = -1; early_drive = 0;
    for (int k = 0; k < 30; k++) begin
      if (req_ready && rdy_k < 0) rdy_k = k;
      if (!sram_we_n && we_k < 0) we_k = k;
      if (we_k < 0 && k >= EXP_RD && sram_dq_oe != 0) early_drive = 1;
      if (k == 20) req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    shadow[8'h99] = 16'h4C3D;
    check(rdy_k == EXP_RD + EXP_TA, "R8 ready only idle", rdy_k, EXP_RD + EXP_TA);
    check(we_k == EXP_RD + EXP_TA + 1, "R8 held accept", we_k, EXP_RD + EXP_TA + 1);
    check(!early_drive, "R7 no early drive", int'(early_drive), 0);
    run_access(1'b0, 18'h00099, 16'h0, 2'b11);
    check(o_rdata == 16'h4C3D, "R8 write landed", int'(o_rdata), 'h4C3D);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = 16'h0000;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_write_read();
    t_byte_lanes();
    t_empty_mask();
    t_busy_hold();
    @(negedge clk);
    t_reset();
    finish_run();
  end

endmodule